// File: doc/BRIEF.md
# Multi-Queue DMA Start/Stop Controller

This block keeps the control-plane state of one receive DMA channel and a parameterised number of transmit queues. Each transmit queue has a start request, a stop request, an early-termination control, a descriptor pointer, a sticky error flag and a pending-frame counter. The counter is fed by frame-queued and frame-done pulses from a modelled datapath. A start makes a queue active. A stop request puts the queue into a draining phase. The queue leaves the active state only once its pending count has reached zero. The drain is paced either by frame-done pulses or, with early termination set, by a flush that discards one frame per cycle.

Descriptor pointers can only be loaded while their channel is idle. A refused load, or a start issued while a stop is still being carried out, raises a sticky error flag that is cleared by writing 1 to it. The receive channel follows the same start/stop scheme. Its stop completes when the datapath reports that it is quiet.

All outputs are registered, and every effect of an input pulse is visible after the next rising clock edge.

Top module: `dmaq_ctl`

## Requirements
- R1: After reset, every queue and the receive channel are inactive, with no stop pending, pending counts zero, pointers zero and error flags clear.
- R2: A start pulse to an idle queue makes it active at the next edge. If the start pulse and a stop pulse arrive in the same cycle on an idle queue, the start has no effect. A start to an already running queue changes nothing.
- R3: A start pulse to a queue whose stop request is still set is refused: the queue's state is unchanged and its error flag is set.
- R4: A stop pulse to a running queue sets its stop-request output. The queue stays active until its pending count reaches zero. The active and stop-request outputs both clear at the edge where the count becomes zero. A stop pulse to an idle queue is ignored.
- R5: While a queue runs without a stop request, each queued pulse adds one and each done pulse subtracts one. Both pulses in the same cycle leave the count unchanged. The count saturates at its maximum and never goes below zero. An idle queue always reads zero.
- R6: While a queue is stopping with early termination clear, each done pulse decrements the count by one.
- R7: While a queue is stopping with early termination set, the count decrements by one every cycle, whatever the done input does.
- R8: Queued pulses to a queue that is idle or stopping are ignored.
- R9: A descriptor-pointer write to a queue that is active (running or stopping) is refused: the pointer keeps its value and the error flag is set. A write to an idle queue loads the pointer at the next edge.
- R10: An error flag clears when 1 is written to its clear input. A new error in the same cycle wins over the clear.
- R11: A receive start makes an idle receive channel active. A receive stop moves a running channel into stopping, and the channel stays active until the cycle in which the quiet input is high. Start while stopping, and stop while idle, are ignored.
- R12: A receive descriptor-pointer write while the receive channel is active is refused, leaves the pointer unchanged and sets a sticky receive error flag. The flag clears on a write of 1, and a new error wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_start_i | input | 1 | Receive start pulse |
| rx_stop_i | input | 1 | Receive stop request pulse |
| rx_quiet_i | input | 1 | Datapath reports receive side quiesced |
| rx_dp_wr_i | input | 1 | Receive descriptor pointer write strobe |
| rx_dp_data_i | input | AW | Receive descriptor pointer write data |
| rx_err_clr_i | input | 1 | Write-1 clear of the receive error flag |
| rx_active_o | output | 1 | Receive channel active |
| rx_dp_o | output | AW | Receive descriptor pointer |
| rx_err_o | output | 1 | Receive sticky error flag |
| tq_start_i | input | NQ | Per-queue start pulses |
| tq_stop_i | input | NQ | Per-queue stop request pulses |
| tq_early_i | input | NQ | Per-queue early-termination control levels |
| tq_queued_i | input | NQ | Per-queue frame-queued pulses |
| tq_done_i | input | NQ | Per-queue frame-done pulses |
| tq_dp_wr_i | input | NQ | Per-queue descriptor pointer write strobes |
| tq_dp_data_i | input | AW | Shared descriptor pointer write data |
| tq_err_clr_i | input | NQ | Per-queue write-1 clear of error flags |
| tq_active_o | output | NQ | Per-queue active status |
| tq_stopreq_o | output | NQ | Per-queue stop request still pending |
| tq_pend_o | output | NQ*CW | Pending-frame counts, queue q at bits q*CW upward |
| tq_dp_o | output | NQ*AW | Descriptor pointers, queue q at bits q*AW upward |
| tq_err_o | output | NQ | Per-queue sticky error flags |

## Verification
Every result, whether a phase change, a counter step, a pointer load or an error flag, is due exactly one rising edge after the input pulse that causes it. A stop completes at the same edge that drives the count to zero. The bench drives inputs on the falling edge and advances its reference state for that stimulus. It then waits one rising edge and compares all outputs on the following falling edge. No result can therefore be taken early or late. Directed sequences reach counter saturation, refused starts and pointer loads, both drain modes and a clear that collides with a new error, and seeded random traffic then mixes all inputs.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;
   // channel phase shared by transmit queues and the receive channel
   typedef enum logic [1:0] {
      QP_IDLE = 2'd0,
      QP_RUN  = 2'd1,
      QP_STOP = 2'd2
   } q_phase_e;
endpackage

// File: rtl/dmaq_txslot.sv
module dmaq_txslot
   import dmaq_pkg::*;
#(
   parameter int AW = 32,
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          stop_i,
   input  logic          early_i,
   input  logic          queued_i,
   input  logic          done_i,
   input  logic          dp_wr_i,
   input  logic [AW-1:0] dp_data_i,
   input  logic          err_clr_i,
   output logic          active_o,
   output logic          stopreq_o,
   output logic [CW-1:0] pend_o,
   output logic [AW-1:0] dp_o,
   output logic          err_o
);
   localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};
   localparam logic [CW-1:0] CNT_ONE = {{(CW-1){1'b0}}, 1'b1};

   q_phase_e      ph_q, ph_d;
   logic [CW-1:0] pend_q, pend_d;
   logic [AW-1:0] dp_q;
   logic          err_q;
   logic          inc, dec, start_rej, dp_rej;

   always_comb begin
      inc = (ph_q == QP_RUN) && queued_i && !done_i && (pend_q != CNT_MAX);
      dec = (pend_q != '0) &&
            (((ph_q == QP_RUN) && done_i && !queued_i) ||
             ((ph_q == QP_STOP) && (early_i || done_i)));
      pend_d = pend_q;
      if (inc)      pend_d = pend_q + CNT_ONE;
      else if (dec) pend_d = pend_q - CNT_ONE;
      ph_d = ph_q;
      unique case (ph_q)
         QP_IDLE: if (start_i && !stop_i) ph_d = QP_RUN;
         QP_RUN:  if (stop_i) ph_d = QP_STOP;
         QP_STOP: if (pend_d == '0) ph_d = QP_IDLE;
         default: ph_d = QP_IDLE;
      endcase
      start_rej = start_i && (ph_q == QP_STOP);
      dp_rej    = dp_wr_i && (ph_q != QP_IDLE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= QP_IDLE;
         pend_q <= '0;
         dp_q   <= '0;
         err_q  <= 1'b0;
      end else begin
         ph_q   <= ph_d;
         pend_q <= pend_d;
         if (dp_wr_i && (ph_q == QP_IDLE)) dp_q <= dp_data_i;
         err_q  <= (err_q && !err_clr_i) || start_rej || dp_rej;
      end
   end

   assign active_o  = (ph_q != QP_IDLE);
   assign stopreq_o = (ph_q == QP_STOP);
   assign pend_o    = pend_q;
   assign dp_o      = dp_q;
   assign err_o     = err_q;

   // R4
   stop_only_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active_o) |-> $past(stopreq_o));
   // R8
   pend_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stopreq_o |=> (pend_o <= $past(pend_o)));
   // R7
   early_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stopreq_o && early_i && (pend_o != '0)) |=> (pend_o == ($past(pend_o) - CNT_ONE)));
   // R9
   dp_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active_o |=> $stable(dp_o));
   // R3
   start_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stopreq_o && start_i) |=> err_o);
   // R5
   idle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active_o |-> (pend_o == '0));
endmodule

// File: rtl/dmaq_rxchan.sv
module dmaq_rxchan
   import dmaq_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          stop_i,
   input  logic          quiet_i,
   input  logic          dp_wr_i,
   input  logic [AW-1:0] dp_data_i,
   input  logic          err_clr_i,
   output logic          active_o,
   output logic [AW-1:0] dp_o,
   output logic          err_o
);
   q_phase_e      ph_q, ph_d;
   logic [AW-1:0] dp_q;
   logic          err_q;

   always_comb begin
      ph_d = ph_q;
      unique case (ph_q)
         QP_IDLE: if (start_i && !stop_i) ph_d = QP_RUN;
         QP_RUN:  if (stop_i) ph_d = QP_STOP;
         QP_STOP: if (quiet_i) ph_d = QP_IDLE;
         default: ph_d = QP_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= QP_IDLE;
         dp_q  <= '0;
         err_q <= 1'b0;
      end else begin
         ph_q  <= ph_d;
         if (dp_wr_i && (ph_q == QP_IDLE)) dp_q <= dp_data_i;
         err_q <= (err_q && !err_clr_i) || (dp_wr_i && (ph_q != QP_IDLE));
      end
   end

   assign active_o = (ph_q != QP_IDLE);
   assign dp_o     = dp_q;
   assign err_o    = err_q;

   // R11
   rx_quiet_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active_o) |-> $past(quiet_i));
   // R12
   rx_dp_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active_o |=> $stable(dp_o));
endmodule

// File: rtl/dmaq_ctl.sv
module dmaq_ctl #(
   parameter int NQ = 4,
   parameter int AW = 32,
   parameter int CW = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_start_i,
   input  logic             rx_stop_i,
   input  logic             rx_quiet_i,
   input  logic             rx_dp_wr_i,
   input  logic [AW-1:0]    rx_dp_data_i,
   input  logic             rx_err_clr_i,
   output logic             rx_active_o,
   output logic [AW-1:0]    rx_dp_o,
   output logic             rx_err_o,
   input  logic [NQ-1:0]    tq_start_i,
   input  logic [NQ-1:0]    tq_stop_i,
   input  logic [NQ-1:0]    tq_early_i,
   input  logic [NQ-1:0]    tq_queued_i,
   input  logic [NQ-1:0]    tq_done_i,
   input  logic [NQ-1:0]    tq_dp_wr_i,
   input  logic [AW-1:0]    tq_dp_data_i,
   input  logic [NQ-1:0]    tq_err_clr_i,
   output logic [NQ-1:0]    tq_active_o,
   output logic [NQ-1:0]    tq_stopreq_o,
   output logic [NQ*CW-1:0] tq_pend_o,
   output logic [NQ*AW-1:0] tq_dp_o,
   output logic [NQ-1:0]    tq_err_o
);
   if (NQ < 1 || NQ > 32) begin : g_bad_nq
      $error("dmaq_ctl: NQ must lie in 1..32");
   end
   if (AW < 1) begin : g_bad_aw
      $error("dmaq_ctl: AW must be positive");
   end
   if (CW < 2 || CW > 16) begin : g_bad_cw
      $error("dmaq_ctl: CW must lie in 2..16");
   end

   dmaq_rxchan #(.AW(AW)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (rx_start_i),
      .stop_i    (rx_stop_i),
      .quiet_i   (rx_quiet_i),
      .dp_wr_i   (rx_dp_wr_i),
      .dp_data_i (rx_dp_data_i),
      .err_clr_i (rx_err_clr_i),
      .active_o  (rx_active_o),
      .dp_o      (rx_dp_o),
      .err_o     (rx_err_o)
   );

   for (genvar q = 0; q < NQ; q++) begin : g_q
      dmaq_txslot #(.AW(AW), .CW(CW)) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .start_i   (tq_start_i[q]),
         .stop_i    (tq_stop_i[q]),
         .early_i   (tq_early_i[q]),
         .queued_i  (tq_queued_i[q]),
         .done_i    (tq_done_i[q]),
         .dp_wr_i   (tq_dp_wr_i[q]),
         .dp_data_i (tq_dp_data_i),
         .err_clr_i (tq_err_clr_i[q]),
         .active_o  (tq_active_o[q]),
         .stopreq_o (tq_stopreq_o[q]),
         .pend_o    (tq_pend_o[q*CW +: CW]),
         .dp_o      (tq_dp_o[q*AW +: AW]),
         .err_o     (tq_err_o[q])
      );
   end
endmodule

// File: tb/sim_dmaq_ctl.sv
`timescale 1ns/1ps
module sim_dmaq_ctl;
   localparam int NQ = 4;
   localparam int AW = 16;
   localparam int CW = 3;
   localparam int PMAX = (1 << CW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic rx_start = 0, rx_stop = 0, rx_quiet = 0, rx_dp_wr = 0, rx_err_clr = 0;
   logic [AW-1:0] rx_dp_data = '0;
   logic rx_active, rx_err;
   logic [AW-1:0] rx_dp;
   logic [NQ-1:0] t_start = 0, t_stop = 0, t_early = 0, t_queued = 0, t_done = 0, t_dpwr = 0, t_clr = 0;
   logic [AW-1:0] t_data = '0;
   logic [NQ-1:0] t_active, t_stopreq, t_err;
   logic [NQ*CW-1:0] t_pend;
   logic [NQ*AW-1:0] t_dp;

   dmaq_ctl #(.NQ(NQ), .AW(AW), .CW(CW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .rx_start_i(rx_start), .rx_stop_i(rx_stop), .rx_quiet_i(rx_quiet),
      .rx_dp_wr_i(rx_dp_wr), .rx_dp_data_i(rx_dp_data), .rx_err_clr_i(rx_err_clr),
      .rx_active_o(rx_active), .rx_dp_o(rx_dp), .rx_err_o(rx_err),
      .tq_start_i(t_start), .tq_stop_i(t_stop), .tq_early_i(t_early),
      .tq_queued_i(t_queued), .tq_done_i(t_done), .tq_dp_wr_i(t_dpwr),
      .tq_dp_data_i(t_data), .tq_err_clr_i(t_clr),
      .tq_active_o(t_active), .tq_stopreq_o(t_stopreq), .tq_pend_o(t_pend),
      .tq_dp_o(t_dp), .tq_err_o(t_err)
   );

   int total = 0;
   int bad = 0;
   bit finished = 0;

   // reference state: phase 0 idle, 1 running, 2 stopping
   int m_rph = 0;
   int m_rdp = 0;
   bit m_rerr = 0;
   int m_ph[NQ];
   int m_pend[NQ];
   int m_dp[NQ];
   bit m_err[NQ];

   task automatic chk(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int f_pend(int ph, int p, bit qd, bit dn, bit early);
      if (ph == 1) begin
         if (qd && !dn && p < PMAX) return p + 1;
         if (dn && !qd && p > 0) return p - 1;
         return p;
      end
      if (ph == 2) begin
         if (p > 0 && (early || dn)) return p - 1;
         return p;
      end
      return p;
   endfunction

   function automatic int f_phase(int ph, bit st, bit sp, int np);
      if (ph == 0) return (st && !sp) ? 1 : 0;
      if (ph == 1) return sp ? 2 : 1;
      return (np == 0) ? 0 : 2;
   endfunction

   task automatic compare_all();
      chk("R11 rx active", int'(rx_active), int'(m_rph != 0));
      chk("R12 rx pointer", int'(rx_dp), m_rdp);
      chk("R12 rx error", int'(rx_err), int'(m_rerr));
      for (int q = 0; q < NQ; q++) begin
         chk($sformatf("R2 R4 q%0d active", q), int'(t_active[q]), int'(m_ph[q] != 0));
         chk($sformatf("R3 R4 q%0d stopreq", q), int'(t_stopreq[q]), int'(m_ph[q] == 2));
         chk($sformatf("R5 R6 R7 R8 q%0d pend", q), int'(t_pend[q*CW +: CW]), m_pend[q]);
         chk($sformatf("R9 q%0d pointer", q), int'(t_dp[q*AW +: AW]), m_dp[q]);
         chk($sformatf("R3 R9 R10 q%0d error", q), int'(t_err[q]), int'(m_err[q]));
      end
   endtask

   task automatic tick();
      int nph;
      int np;
      nph = (m_rph == 0) ? ((rx_start && !rx_stop) ? 1 : 0) :
            (m_rph == 1) ? (rx_stop ? 2 : 1) : (rx_quiet ? 0 : 2);
      m_rerr = (m_rerr && !rx_err_clr) || (rx_dp_wr && m_rph != 0);
      if (rx_dp_wr && m_rph == 0) m_rdp = int'(rx_dp_data);
      m_rph = nph;
      for (int q = 0; q < NQ; q++) begin
         np = f_pend(m_ph[q], m_pend[q], t_queued[q], t_done[q], t_early[q]);
         m_err[q] = (m_err[q] && !t_clr[q]) || (t_start[q] && m_ph[q] == 2) ||
                    (t_dpwr[q] && m_ph[q] != 0);
         if (t_dpwr[q] && m_ph[q] == 0) m_dp[q] = int'(t_data);
         m_ph[q] = f_phase(m_ph[q], t_start[q], t_stop[q], np);
         m_pend[q] = np;
      end
      @(posedge clk);
      @(negedge clk);
      compare_all();
      rx_start = 0; rx_stop = 0; rx_dp_wr = 0; rx_err_clr = 0;
      t_start = 0; t_stop = 0; t_queued = 0; t_done = 0; t_dpwr = 0; t_clr = 0;
   endtask

   initial begin
      #100us;
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog: got 1 expected 0");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = $urandom(32'h1d2c);
      for (int q = 0; q < NQ; q++) begin
         m_ph[q] = 0; m_pend[q] = 0; m_dp[q] = 0; m_err[q] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 rx active", int'(rx_active), 0);
      chk("R1 tx active", int'(t_active), 0);
      chk("R1 tx pend", int'(t_pend), 0);
      chk("R1 errors", int'(t_err) + int'(rx_err), 0);
      compare_all();

      // R2, R5: start q0, over-fill to saturation
      t_start[0] = 1; tick();
      for (int i = 0; i < PMAX + 2; i++) begin t_queued[0] = 1; tick(); end
      t_queued[0] = 1; t_done[0] = 1; tick();
      // R9: pointer write while active refused, then R10 clear
      t_data = 16'hA5A5; t_dpwr[0] = 1; tick();
      t_clr[0] = 1; tick();
      // R10: clear collides with new error
      t_dpwr[0] = 1; tick();
      t_clr[0] = 1; t_dpwr[0] = 1; tick();
      t_clr[0] = 1; tick();
      // R4, R6, R8: normal drain with refused start
      t_stop[0] = 1; tick();
      t_queued[0] = 1; tick();
      t_start[0] = 1; tick();
      for (int i = 0; i < PMAX + 1; i++) begin t_done[0] = 1; tick(); tick(); end
      // R9: idle write accepted
      t_data = 16'h1234; t_dpwr[0] = 1; tick();
      // R7: early flush on q1
      t_start[1] = 1; tick();
      repeat (4) begin t_queued[1] = 1; tick(); end
      t_early[1] = 1; t_stop[1] = 1; tick();
      repeat (5) tick();
      t_early[1] = 0;
      // R4: stop on idle q2 ignored; R2 start+stop together on idle q3
      t_stop[2] = 1; tick();
      t_start[3] = 1; t_stop[3] = 1; tick();
      // R11, R12 receive channel
      rx_dp_data = 16'h0BEE; rx_dp_wr = 1; tick();
      rx_start = 1; tick();
      rx_dp_data = 16'h7777; rx_dp_wr = 1; tick();
      rx_stop = 1; tick();
      rx_start = 1; tick();
      tick();
      rx_quiet = 1; tick();
      rx_quiet = 0; rx_err_clr = 1; tick();

      // constrained random traffic
      for (int c = 0; c < 4000; c++) begin
         for (int q = 0; q < NQ; q++) begin
            t_start[q]  = ($urandom % 8) == 0;
            t_stop[q]   = ($urandom % 16) == 0;
            t_queued[q] = ($urandom % 3) == 0;
            t_done[q]   = ($urandom % 4) == 0;
            t_dpwr[q]   = ($urandom % 10) == 0;
            t_clr[q]    = ($urandom % 12) == 0;
            if (($urandom % 50) == 0) t_early[q] = ~t_early[q];
         end
         t_data     = AW'($urandom);
         rx_start   = ($urandom % 10) == 0;
         rx_stop    = ($urandom % 16) == 0;
         rx_quiet   = ($urandom % 4) == 0;
         rx_dp_wr   = ($urandom % 8) == 0;
         rx_err_clr = ($urandom % 10) == 0;
         rx_dp_data = AW'($urandom);
         tick();
      end
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule